// File: doc/BRIEF.md
# Parallel NOR Flash Command Interpreter

This block stands in for a parallel NOR flash device that follows the common query-capable command set, with the array held in on-chip byte RAM. A host reaches it through a simple synchronous slave port. Each access carries a byte address, write data, an access size of one, two or four bytes, and a byte-order select. A read returns its data one clock after the read strobe.

Every bus write passes through a multi-cycle command sequencer. The sequencer decides whether a later read returns array contents, the status byte, identifier words or query-table bytes. It also walks the cycles of program, sector erase, buffered write and lock handshakes. Commands are taken from the low 8 bits of the write data.

A sector erase sweeps the sector one byte per clock. While the sweep runs the device is busy: status bit 7 reads as 0 and bus writes are dropped. When the sweep ends, status bit 7 is set. Lock and unlock only complete their handshake and do not protect anything.

Top module: `nor_cmd_flash`

## Requirements
- R1: A synchronous active-high reset leaves the device in array-read mode with no command pending and the status byte at 0x00; read data appears on `rd_data` one clock after `rd_en`.
- R2: In array-read mode, writing 0xFF or 0x00 keeps array-read mode. Writing 0x50 clears the status byte to 0x00 and returns to array-read mode.
- R3: Writing 0x40 or 0x10 arms a program. The next write stores its data at its address, sets status bit 7 and returns to array-read mode.
- R4: Writing 0x20 fills the sector that holds the address (address aligned down to a multiple of 2^SECTOR_W bytes) with 0xFF, one byte per clock. During the sweep, status bit 7 reads 0 and bus writes are ignored. At the end of the sweep, bit 7 is set.
- R5: After the 0x20 command, the next write decides the outcome. 0xD0 finishes with status bit 7 set and status still readable. 0xFF, or any other value, returns to array-read mode.
- R6: Writing 0xE8 starts a buffered write. The next write gives a count N. The following N+1 writes are each stored at their own address. Then 0xD0 confirms, or any other value resets to array-read mode with the data already stored.
- R7: While command 0x20, 0x60, 0x70 or 0xE8 is pending, every read returns the status byte in bits 7:0 with zeros above.
- R8: After 0x90, a read at word index 0 returns {ID0,ID1}, index 1 returns {ID2,ID3}, and any other index returns 0.
- R9: After 0x98, a read returns the query-table byte at the word index. Query bytes 0x10..0x12 are "Q","R","Y" and byte 0x27 is ADDR_W. An index above 0x52 returns 0. Any write other than 0xFF keeps query mode, and 0xFF leaves it.
- R10: Writing 0x60 arms lock/unlock. A second write of 0xD0 or 0x01 completes it with status bit 7 set, and any other value returns to array-read mode.
- R11: The word index for identifier and query reads is address bits 7:0 shifted right by 1 when PORT_BYTES is 2, or by 2 when PORT_BYTES is 4. Higher address bits are ignored.
- R12: The access size is encoded on `bus_size` as 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes. With `bus_be` = 1, the byte at the lowest address is the most significant; with 0, it is the least significant. This order applies to both array reads and array writes.
- R13: In array-read mode, any command byte not listed above returns the device to array-read mode with nothing pending. This includes a new byte written while status or identifier reads are active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data; command byte in bits 7:0 |
| bus_size | input | 2 | Access size: 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes |
| bus_be | input | 1 | 1 = big-endian byte order, 0 = little-endian |
| wr_en | input | 1 | Write strobe, one clock per write |
| rd_en | input | 1 | Read strobe; data follows one clock later |
| rd_data | output | 32 | Registered read data |

## Verification
The hardest situation to reach from the ports is a bus write that arrives in the middle of an erase sweep, because the sweep window is only a few hundred clocks long. The stimulus issues the erase command and immediately reads status to see bit 7 clear. It then sends 0xFF while the sweep is still running, and reads again to show that the sequencer did not leave status mode. After that it polls status until bit 7 rises, and only then sends the confirm. Buffered writes are driven with a small count so that the final data write and the confirm cycle both fall within the same short sequence.

// File: rtl/nor_cmd_flash.sv
module nor_cmd_flash #(
  parameter int ADDR_W = 10,
  parameter int SECTOR_W = 8,
  parameter int PORT_BYTES = 2,
  parameter int CNT_W = 16,
  parameter logic [7:0] ID0 = 8'h89,
  parameter logic [7:0] ID1 = 8'h00,
  parameter logic [7:0] ID2 = 8'h00,
  parameter logic [7:0] ID3 = 8'h18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic [1:0]        bus_size,
  input  logic              bus_be,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic [31:0]       rd_data
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int SECT_BYTES = 1 << SECTOR_W;
  localparam int NSECT = 1 << (ADDR_W - SECTOR_W);
  localparam int IDX_SH = (PORT_BYTES == 4) ? 2 : (PORT_BYTES == 2) ? 1 : 0;
  localparam logic [7:0] QLEN = 8'h52;
  localparam logic [7:0] BUF_LOG = (PORT_BYTES == 1) ? 8'h08 : 8'h0B;

  localparam logic [7:0] C_RST0 = 8'h00, C_PROG1 = 8'h10, C_ERASE = 8'h20, C_PROG2 = 8'h40;
  localparam logic [7:0] C_CLR = 8'h50, C_LOCK = 8'h60, C_STAT = 8'h70, C_ID = 8'h90;
  localparam logic [7:0] C_QRY = 8'h98, C_BUF = 8'hE8, C_ARR = 8'hFF, C_OK = 8'hD0, C_LK1 = 8'h01;

  logic [7:0] mem [DEPTH];

  logic [7:0]              cmd;
  logic [1:0]              wcycle;
  logic [7:0]              status;
  logic                    busy;
  logic [SECTOR_W-1:0]     sweep_ptr;
  logic [ADDR_W-SECTOR_W-1:0] sweep_base;
  logic [CNT_W-1:0]        cnt;
  logic [31:0]             rd_q;

  wire [7:0] wbyte = bus_wdata[7:0];
  wire take = wr_en & ~busy;
  wire prog_we = take && wcycle == 2'd1 && (cmd == C_PROG1 || cmd == C_PROG2);
  wire buf_we = take && wcycle == 2'd2 && cmd == C_BUF;
  wire [7:0] stat_vis = busy ? {1'b0, status[6:0]} : status;
  wire [7:0] idx = bus_addr[7:0] >> IDX_SH;

  logic [7:0] lane [4];
  logic [3:0] lane_en;
  logic [7:0] rbyte [4];
  logic [31:0] arr, rd_val;

  always_comb begin
    for (int k = 0; k < 4; k++) lane[k] = bus_wdata[8*k +: 8];
    lane_en = 4'b1111;
    case (bus_size)
      2'd0: lane_en = 4'b0001;
      2'd1: begin
        lane_en = 4'b0011;
        if (bus_be) begin
          lane[0] = bus_wdata[15:8];
          lane[1] = bus_wdata[7:0];
        end
      end
      default: if (bus_be) begin
        lane[0] = bus_wdata[31:24];
        lane[1] = bus_wdata[23:16];
        lane[2] = bus_wdata[15:8];
        lane[3] = bus_wdata[7:0];
      end
    endcase
  end

  always_comb begin
    for (int k = 0; k < 4; k++) rbyte[k] = mem[bus_addr + ADDR_W'(k)];
    case (bus_size)
      2'd0: arr = {24'b0, rbyte[0]};
      2'd1: arr = bus_be ? {16'b0, rbyte[0], rbyte[1]} : {16'b0, rbyte[1], rbyte[0]};
      default: arr = bus_be ? {rbyte[0], rbyte[1], rbyte[2], rbyte[3]}
                            : {rbyte[3], rbyte[2], rbyte[1], rbyte[0]};
    endcase
  end

  function automatic logic [7:0] qbyte(input logic [7:0] i);
    case (i)
      8'h10: qbyte = 8'h51;
      8'h11: qbyte = 8'h52;
      8'h12: qbyte = 8'h59;
      8'h13: qbyte = 8'h01;
      8'h15: qbyte = 8'h31;
      8'h1B: qbyte = 8'h45;
      8'h1C: qbyte = 8'h55;
      8'h1F, 8'h20: qbyte = 8'h07;
      8'h21: qbyte = 8'h0A;
      8'h23, 8'h24, 8'h25: qbyte = 8'h04;
      8'h27: qbyte = 8'(ADDR_W);
      8'h28: qbyte = 8'h02;
      8'h2A: qbyte = BUF_LOG;
      8'h2C: qbyte = 8'h01;
      8'h2D: qbyte = 8'((NSECT - 1) & 255);
      8'h2E: qbyte = 8'(((NSECT - 1) >> 8) & 255);
      8'h2F: qbyte = 8'((SECT_BYTES >> 8) & 255);
      8'h30: qbyte = 8'((SECT_BYTES >> 16) & 255);
      8'h31: qbyte = 8'h50;
      8'h32: qbyte = 8'h52;
      8'h33: qbyte = 8'h49;
      8'h34, 8'h35: qbyte = 8'h31;
      default: qbyte = 8'h00;
    endcase
  endfunction

  always_comb begin
    case (cmd)
      C_ERASE, C_CLR, C_LOCK, C_STAT, C_BUF: rd_val = {24'b0, stat_vis};
      C_ID: rd_val = (idx == 8'd0) ? {16'b0, ID0, ID1} :
                     (idx == 8'd1) ? {16'b0, ID2, ID3} : 32'b0;
      C_QRY: rd_val = (idx > QLEN) ? 32'b0 : {24'b0, qbyte(idx)};
      default: rd_val = arr;
    endcase
  end

  always_ff @(posedge clk) begin
    if (busy)
      mem[{sweep_base, sweep_ptr}] <= 8'hFF;
    else if (prog_we || buf_we)
      for (int k = 0; k < 4; k++)
        if (lane_en[k]) mem[bus_addr + ADDR_W'(k)] <= lane[k];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd <= C_RST0;
      wcycle <= 2'd0;
      status <= 8'h00;
      busy <= 1'b0;
      sweep_ptr <= '0;
      sweep_base <= '0;
      cnt <= '0;
      rd_q <= '0;
    end else begin
      if (busy) begin
        sweep_ptr <= sweep_ptr + 1'b1;
        if (&sweep_ptr) begin
          busy <= 1'b0;
          status[7] <= 1'b1;
        end
      end
      if (take) begin
        case (wcycle)
          2'd0: begin
            case (wbyte)
              C_PROG1, C_PROG2, C_LOCK, C_QRY: begin
                cmd <= wbyte;
                wcycle <= 2'd1;
              end
              C_ERASE: begin
                cmd <= wbyte;
                wcycle <= 2'd1;
                busy <= 1'b1;
                sweep_ptr <= '0;
                sweep_base <= bus_addr[ADDR_W-1:SECTOR_W];
                status[7] <= 1'b0;
              end
              C_BUF: begin
                cmd <= wbyte;
                wcycle <= 2'd1;
                status[7] <= 1'b1;
              end
              C_STAT, C_ID: cmd <= wbyte;
              C_CLR: begin
                status <= 8'h00;
                cmd <= C_RST0;
              end
              default: cmd <= C_RST0;
            endcase
          end
          2'd1: begin
            case (cmd)
              C_PROG1, C_PROG2: begin
                status[7] <= 1'b1;
                cmd <= C_RST0;
                wcycle <= 2'd0;
              end
              C_ERASE: begin
                wcycle <= 2'd0;
                if (wbyte == C_OK) status[7] <= 1'b1;
                else cmd <= C_RST0;
              end
              C_LOCK: begin
                wcycle <= 2'd0;
                if (wbyte == C_OK || wbyte == C_LK1) status[7] <= 1'b1;
                else cmd <= C_RST0;
              end
              C_BUF: begin
                cnt <= bus_wdata[CNT_W-1:0];
                wcycle <= 2'd2;
              end
              C_QRY: if (wbyte == C_ARR) begin
                cmd <= C_RST0;
                wcycle <= 2'd0;
              end
              default: begin
                cmd <= C_RST0;
                wcycle <= 2'd0;
              end
            endcase
          end
          2'd2: begin
            if (cmd == C_BUF) begin
              status[7] <= 1'b1;
              cnt <= cnt - 1'b1;
              if (cnt == '0) wcycle <= 2'd3;
            end else begin
              cmd <= C_RST0;
              wcycle <= 2'd0;
            end
          end
          default: begin
            wcycle <= 2'd0;
            if (cmd == C_BUF && wbyte == C_OK) status[7] <= 1'b1;
            else cmd <= C_RST0;
          end
        endcase
      end
      if (rd_en) rd_q <= rd_val;
    end
  end

  assign rd_data = rd_q;
endmodule

// File: rtl/nor_cmd_flash_chk.sv
module nor_cmd_flash_chk #(
  parameter int SECTOR_W = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                wr_en,
  input logic                rd_en,
  input logic                busy,
  input logic [7:0]          cmd,
  input logic [1:0]          wcycle,
  input logic [7:0]          status,
  input logic [SECTOR_W-1:0] sweep_ptr,
  input logic [31:0]         rd_data
);
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (cmd == 8'h00 && wcycle == 2'd0 && status == 8'h00 && !busy));

  assert_sweep_steps_R4: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> sweep_ptr == SECTOR_W'($past(sweep_ptr) + 1'b1));

  assert_sweep_done_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> status[7]);

  assert_busy_ignores_writes_R4: assert property (@(posedge clk) disable iff (rst)
    (busy && wr_en) |=> ($stable(cmd) && $stable(wcycle)));

  assert_buffer_only_R6: assert property (@(posedge clk) disable iff (rst)
    (wcycle[1]) |-> cmd == 8'hE8);

  assert_status_read_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !wr_en && !busy && cmd == 8'h70) |=> rd_data == {24'b0, $past(status)});
endmodule

bind nor_cmd_flash nor_cmd_flash_chk #(.SECTOR_W(SECTOR_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .busy(busy), .cmd(cmd),
  .wcycle(wcycle), .status(status), .sweep_ptr(sweep_ptr), .rd_data(rd_data)
);

// File: tb/nor_cmd_flash_tb.sv
`timescale 1ns/1ps
module nor_cmd_flash_tb;
  localparam int AW = 10;
  localparam int DEPTH = 1 << AW;

  logic clk = 0, rst = 1;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [1:0] bus_size = 2'd0;
  logic bus_be = 0, wr_en = 0, rd_en = 0;
  logic [31:0] rd_data;

  int nchk = 0, nerr = 0;
  bit done = 0;
  logic [7:0] ref_mem [DEPTH];

  always #2 clk = ~clk;

  nor_cmd_flash #(.ADDR_W(AW), .SECTOR_W(8), .PORT_BYTES(2), .CNT_W(16),
    .ID0(8'h89), .ID1(8'h00), .ID2(8'h00), .ID3(8'h18)) u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_size(bus_size), .bus_be(bus_be), .wr_en(wr_en), .rd_en(rd_en), .rd_data(rd_data));

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d, input int sz, input bit be);
    @(negedge clk);
    bus_addr = AW'(a); bus_wdata = d; bus_size = 2'(sz); bus_be = be; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input int a, input int sz, input bit be, output logic [31:0] v);
    @(negedge clk);
    bus_addr = AW'(a); bus_size = 2'(sz); bus_be = be; rd_en = 1;
    @(negedge clk);
    rd_en = 0;
    v = rd_data;
  endtask

  function automatic int nb(input int sz);
    return sz == 0 ? 1 : sz == 1 ? 2 : 4;
  endfunction

  task automatic mput(input int a, input logic [31:0] d, input int sz, input bit be);
    int n = nb(sz);
    for (int k = 0; k < n; k++)
      ref_mem[(a + k) % DEPTH] = be ? d[8*(n-1-k) +: 8] : d[8*k +: 8];
  endtask

  function automatic logic [31:0] mget(input int a, input int sz, input bit be);
    int n = nb(sz);
    logic [31:0] v = '0;
    for (int k = 0; k < n; k++)
      if (be) v[8*(n-1-k) +: 8] = ref_mem[(a + k) % DEPTH];
      else v[8*k +: 8] = ref_mem[(a + k) % DEPTH];
    return v;
  endfunction

  task automatic wait_ready(input string req);
    logic [31:0] v;
    int n = 0;
    do begin
      rd(0, 0, 0, v);
      n++;
    end while (!v[7] && n < 2000);
    chk(req, {31'b0, v[7]}, 32'd1);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    wr(0, 32'h70, 0, 0);
    rd(0, 0, 0, v); chk("R1 reset status", v, 32'h00);
    wr(0, 32'hFF, 0, 0);
  endtask

  task automatic t_erase_all;
    for (int s = 0; s < 4; s++) begin
      wr(s * 256 + 5, 32'h20, 0, 0);
      wait_ready("R4 erase completes");
      wr(0, 32'hD0, 0, 0);
      wr(0, 32'hFF, 0, 0);
      for (int i = 0; i < 256; i++) ref_mem[s * 256 + i] = 8'hFF;
    end
  endtask

  task automatic t_program;
    logic [31:0] v;
    wr(0, 32'h40, 0, 0); wr(32'h105, 32'hA5, 0, 0); mput(32'h105, 32'hA5, 0, 0);
    rd(32'h105, 0, 0, v); chk("R3 program byte 0x40", v, mget(32'h105, 0, 0));
    wr(0, 32'h10, 0, 0); wr(32'h110, 32'h1234, 1, 1); mput(32'h110, 32'h1234, 1, 1);
    rd(32'h110, 0, 0, v); chk("R12 BE write high byte first", v, 32'h12);
    rd(32'h111, 0, 0, v); chk("R12 BE write low byte second", v, 32'h34);
    wr(0, 32'h70, 0, 0); rd(0, 0, 0, v); chk("R3 program sets bit7", v, 32'h80);
    wr(0, 32'hFF, 0, 0);
  endtask

  task automatic t_endian;
    logic [31:0] v;
    wr(0, 32'h40, 0, 0); wr(32'h120, 32'hDEADBEEF, 2, 0); mput(32'h120, 32'hDEADBEEF, 2, 0);
    rd(32'h120, 2, 1, v); chk("R12 LE write BE read", v, 32'hEFBEADDE);
    rd(32'h120, 1, 0, v); chk("R12 LE 16-bit read", v, 32'h0000BEEF);
    rd(32'h122, 2, 0, v); chk("R12 LE 32-bit read model", v, mget(32'h122, 2, 0));
  endtask

  task automatic t_status_clear;
    logic [31:0] v;
    wr(0, 32'h50, 0, 0);
    rd(32'h105, 0, 0, v); chk("R2 0x50 returns to array", v, 32'hA5);
    wr(0, 32'h70, 0, 0); rd(0, 0, 0, v); chk("R2 0x50 clears status", v, 32'h00);
    wr(0, 32'h00, 0, 0);
    rd(32'h105, 0, 0, v); chk("R2 0x00 returns to array", v, 32'hA5);
    wr(0, 32'hFF, 0, 0);
    rd(32'h105, 0, 0, v); chk("R2 0xFF keeps array", v, 32'hA5);
  endtask

  task automatic t_erase_busy;
    logic [31:0] v;
    wr(0, 32'h40, 0, 0); wr(32'h3F0, 32'h5A, 0, 0);
    wr(32'h3A7, 32'h20, 0, 0);
    rd(0, 0, 0, v); chk("R4 bit7 clear while busy", v, 32'h00);
    wr(0, 32'hFF, 0, 0);
    rd(0, 0, 0, v); chk("R4 write ignored while busy", v, 32'h00);
    wait_ready("R4 bit7 set after sweep");
    for (int i = 0; i < 256; i++) ref_mem[32'h300 + i] = 8'hFF;
    wr(0, 32'hD0, 0, 0);
    rd(0, 0, 0, v); chk("R5 confirm keeps status", v, 32'h80);
    rd(32'h3F0, 0, 0, v); chk("R7 status while erase pending", v, 32'h80);
    wr(0, 32'hFF, 0, 0);
    rd(32'h3F0, 0, 0, v); chk("R4 sector filled", v, 32'hFF);
    rd(32'h300, 2, 0, v); chk("R4 aligned start filled", v, 32'hFFFFFFFF);
    rd(32'h120, 2, 0, v); chk("R4 other sector kept", v, mget(32'h120, 2, 0));
    wr(32'h200, 32'h20, 0, 0); wait_ready("R5 erase for abort");
    wr(0, 32'h33, 0, 0);
    rd(32'h200, 0, 0, v); chk("R5 bad second cycle resets", v, 32'hFF);
    wr(32'h200, 32'h20, 0, 0); wait_ready("R5 erase for FF abort");
    wr(0, 32'hFF, 0, 0);
    rd(32'h201, 0, 0, v); chk("R5 0xFF aborts to array", v, 32'hFF);
    for (int i = 0; i < 256; i++) ref_mem[32'h200 + i] = 8'hFF;
  endtask

  task automatic t_buffer;
    logic [31:0] v;
    wr(0, 32'h50, 0, 0);
    wr(32'h140, 32'hE8, 0, 0);
    rd(0, 0, 0, v); chk("R7 status during buffer", v, 32'h80);
    wr(32'h140, 32'd2, 1, 0);
    wr(32'h140, 32'h1111, 1, 0); mput(32'h140, 32'h1111, 1, 0);
    wr(32'h142, 32'h22FF, 1, 0); mput(32'h142, 32'h22FF, 1, 0);
    wr(32'h144, 32'h3350, 1, 0); mput(32'h144, 32'h3350, 1, 0);
    wr(0, 32'hD0, 0, 0);
    rd(0, 0, 0, v); chk("R6 confirm status", v, 32'h80);
    wr(0, 32'hFF, 0, 0);
    rd(32'h140, 2, 0, v); chk("R6 buffer data low", v, mget(32'h140, 2, 0));
    rd(32'h144, 1, 0, v); chk("R6 third data word", v, 32'h3350);
    rd(32'h146, 1, 0, v); chk("R6 no extra write", v, 32'hFFFF);
    wr(0, 32'hE8, 0, 0); wr(0, 32'd0, 1, 0);
    wr(32'h150, 32'hABCD, 1, 1); mput(32'h150, 32'hABCD, 1, 1);
    wr(0, 32'h77, 0, 0);
    rd(32'h150, 1, 1, v); chk("R6 bad confirm resets to array", v, 32'hABCD);
  endtask

  task automatic t_ident;
    logic [31:0] v;
    wr(0, 32'h90, 0, 0);
    rd(0, 1, 0, v); chk("R8 manufacturer code", v, 32'h8900);
    rd(2, 1, 0, v); chk("R8 device code", v, 32'h0018);
    rd(4, 1, 0, v); chk("R8 other index zero", v, 32'h0);
    rd(1, 1, 0, v); chk("R11 addr 1 maps to index 0", v, 32'h8900);
    rd(32'h302, 1, 0, v); chk("R11 high address bits ignored", v, 32'h0018);
    wr(0, 32'h3C, 0, 0);
    rd(32'h140, 1, 0, v); chk("R13 unknown byte leaves ident", v, 32'h1111);
  endtask

  task automatic t_query;
    logic [31:0] v;
    wr(0, 32'h98, 0, 0);
    rd(32'h20, 0, 0, v); chk("R9 query Q", v, 32'h51);
    rd(32'h22, 0, 0, v); chk("R9 query R", v, 32'h52);
    rd(32'h24, 0, 0, v); chk("R9 query Y", v, 32'h59);
    rd(32'h4E, 0, 0, v); chk("R9 query size byte", v, AW);
    rd(32'hC0, 0, 0, v); chk("R9 beyond table zero", v, 32'h0);
    wr(0, 32'h12, 0, 0);
    rd(32'h20, 0, 0, v); chk("R9 non-FF stays query", v, 32'h51);
    wr(0, 32'hFF, 0, 0);
    rd(32'h20, 0, 0, v); chk("R9 0xFF leaves query", v, mget(32'h20, 0, 0));
  endtask

  task automatic t_lock;
    logic [31:0] v;
    wr(0, 32'h50, 0, 0);
    wr(0, 32'h60, 0, 0); wr(0, 32'h01, 0, 0);
    rd(0, 0, 0, v); chk("R10 0x01 completes", v, 32'h80);
    wr(0, 32'h50, 0, 0);
    wr(0, 32'h60, 0, 0); wr(0, 32'hD0, 0, 0);
    rd(0, 0, 0, v); chk("R10 0xD0 completes", v, 32'h80);
    wr(0, 32'h60, 0, 0); wr(0, 32'h44, 0, 0);
    rd(32'h105, 0, 0, v); chk("R10 other value to array", v, 32'hA5);
    wr(0, 32'h70, 0, 0); wr(0, 32'hC3, 0, 0);
    rd(32'h105, 0, 0, v); chk("R13 unknown command resets", v, 32'hA5);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_erase_all();
    t_program();
    t_endian();
    t_status_clear();
    t_erase_busy();
    t_buffer();
    t_ident();
    t_query();
    t_lock();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      done = 1;
      nchk++; nerr++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule